// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down for a small processor core. The instruction decoder sends it a sleep strobe together with the prefetched address of the following instruction. The block then decides whether the sleep really takes effect. If any enabled interrupt is already pending, the sleep is turned into a no-op that changes nothing. Otherwise the block clears the watchdog, updates two status bits and drops the core oscillator enable. The watchdog counter, the peripherals and the fetch pipeline sit outside the block.

While the core sleeps, only the always-on watchdog time-out and interrupt sources that can raise a flag without the core clock are able to wake it. A parameter mask names those sources. Every wake condition turns the oscillator back on in the cycle it is first seen. The wake event then passes through a short synchronizer into the restarted clock domain. After that, the block issues a one-cycle redirect carrying the saved resume address. A flag on the redirect tells the core whether to run that instruction inline only, or run it and then take the interrupt vector.

An external reset never produces a wake-up. It returns the block to running with no redirect, and the status bits record what happened before the reset. A separate clear-watchdog strobe clears the watchdog and sets both status bits.

Top module: `swk_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `stat_pd` and `stat_to` are 1, `core_clk_en` is 1, and `wdt_clr` and `redir_vld` are 0.
- R2: A `sleep_req` while running with no pending source has these effects, in order. `wdt_clr` is 1 in that same cycle. After the next edge, `stat_pd` reads 0 and `stat_to` reads 1. `core_clk_en` is 0 from the following cycle until a wake condition appears.
- R3: A source is pending when `irq_flag[i]` and `irq_en[i]` are both 1, for any i. A `sleep_req` that arrives while a source is pending is a no-op: `wdt_clr` stays 0, both status bits keep their values, and the clock stays on.
- R4: A `clrwdt_req` while running drives `wdt_clr` to 1 in that cycle, and sets both `stat_pd` and `stat_to` to 1 after the edge. If it arrives in the same cycle as a sleep that takes effect, the sleep's status update wins.
- R5: While asleep, `core_clk_en` is 1 in the same cycle that a wake condition is present. A wake condition is `wdt_tmo` high, or any pending source i with bit i of `WAKE_MASK` set.
- R6: Call the cycle in which the wake condition is seen cycle 0. `redir_vld` is then high for exactly one cycle, in cycle `SYNC_STAGES`+1 (cycle 3 by default), and the clock stays on from cycle 0 onward.
- R7: While `redir_vld` is high, `redir_addr` equals the `pc_next` value sampled with the sleep that took effect. At the same time `redir_vec` equals `gie` as sampled in the wake cycle, and `redir_vec_addr` is 0x0004 when `redir_vec` is 1. Wake-up occurs whether `gie` is 0 or 1. Outside the redirect cycle all three outputs are 0.
- R8: A wake caused by `wdt_tmo` clears `stat_to` after the edge that ends the wake cycle. A wake caused only by an interrupt leaves `stat_to` at 1. `stat_pd` stays 0 in both cases.
- R9: While asleep, a source wakes the core only if flag and enable are both 1 and its `WAKE_MASK` bit is set. The default mask 8'h3F lets sources 0 to 5 wake the core; sources 6 and 7 cannot, but they do still turn a sleep into a no-op under R3.
- R10: `ext_rst` high returns the block to running: `core_clk_en` is 1 and no redirect is ever issued for the interrupted sleep. `stat_pd` and `stat_to` keep their values.
- R11: An enabled source that rises in the cycle right after a sleep that took effect does not undo that sleep: the status bits read pd=0 and to=1, and a normal redirect follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req | input | 1 | Sleep instruction strobe from the decoder |
| clrwdt_req | input | 1 | Clear-watchdog instruction strobe |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| ext_rst | input | 1 | External reset request, synchronous |
| gie | input | 1 | Global interrupt enable |
| irq_flag | input | N_SRC | Interrupt flag per source |
| irq_en | input | N_SRC | Interrupt enable per source |
| pc_next | input | AW | Prefetched address following the sleep |
| core_clk_en | output | 1 | Core oscillator / clock enable |
| wdt_clr | output | 1 | Watchdog clear strobe |
| stat_pd | output | 1 | Power-down status bit (0 = a sleep executed) |
| stat_to | output | 1 | Time-out status bit (0 = watchdog woke the core) |
| redir_vld | output | 1 | One-cycle fetch redirect request |
| redir_addr | output | AW | Resume address for the redirect |
| redir_vec | output | 1 | Take interrupt vector after the resumed instruction |
| redir_vec_addr | output | AW | Vector address, valid with redir_vec |

## Verification
The main decision, whether a sleep takes effect or becomes a no-op, is exercised with several input patterns. The bench issues it with nothing pending, with a wake-capable source pending, and with a masked-off source pending; this separates the "any pending source" check from the "wake-capable" check. The bench also raises sources while asleep with the flag alone, the enable alone, both set on a masked source, and both set on a wake source; only the last may turn the clock on. Wakes come from the watchdog with `gie` set and from interrupts with `gie` clear, and one interrupt rises the cycle after the sleep. Together these tell apart how each wake cause affects the time-out bit, the vector choice and the redirect timing. An external reset during sleep checks that a reset never produces a redirect.

// File: rtl/swk_pkg.sv
package swk_pkg;
   typedef enum logic [1:0] {
      SW_RUN   = 2'd0,
      SW_SLEEP = 2'd1,
      SW_WAKE  = 2'd2
   } swk_state_e;
endpackage

// File: rtl/swk_irq_scan.sv
// Reduces per-source flag/enable pairs to "any pending" and "any able to wake".
module swk_irq_scan #(
   parameter int unsigned          N_SRC     = 8,
   parameter logic [N_SRC-1:0]     WAKE_MASK = '1
) (
   input  logic [N_SRC-1:0] flag,
   input  logic [N_SRC-1:0] en,
   output logic             any_pend,
   output logic             any_wake
);
   logic [N_SRC-1:0] pend_v;
   logic [N_SRC-1:0] wake_v;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign pend_v[i] = flag[i] & en[i];
      if (WAKE_MASK[i]) begin : g_async
         assign wake_v[i] = pend_v[i];
      end else begin : g_clocked
         assign wake_v[i] = 1'b0;
      end
   end

   assign any_pend = |pend_v;
   assign any_wake = |wake_v;
endmodule

// File: rtl/swk_sync.sv
// Multi-stage synchronizer with synchronous clear.
module swk_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   chain[s] <= 1'b0;
            else if (clr) chain[s] <= 1'b0;
            else          chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   chain[s] <= 1'b0;
            else if (clr) chain[s] <= 1'b0;
            else          chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/swk_status.sv
// Power-down and time-out status bits.
module swk_status (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_take,
   input  logic wdt_kick,
   input  logic tmo_wake,
   output logic pd,
   output logic to
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd <= 1'b1;
         to <= 1'b1;
      end else if (sleep_take) begin
         pd <= 1'b0;
         to <= 1'b1;
      end else if (wdt_kick) begin
         pd <= 1'b1;
         to <= 1'b1;
      end else if (tmo_wake) begin
         to <= 1'b0;
      end
   end
endmodule

// File: rtl/swk_ctrl.sv
module swk_ctrl
   import swk_pkg::*;
#(
   parameter int unsigned      N_SRC       = 8,
   parameter int unsigned      AW          = 13,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [N_SRC-1:0] WAKE_MASK   = 8'h3F,
   parameter logic [AW-1:0]    VEC_ADDR    = 13'h0004
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             clrwdt_req,
   input  logic             wdt_tmo,
   input  logic             ext_rst,
   input  logic             gie,
   input  logic [N_SRC-1:0] irq_flag,
   input  logic [N_SRC-1:0] irq_en,
   input  logic [AW-1:0]    pc_next,
   output logic             core_clk_en,
   output logic             wdt_clr,
   output logic             stat_pd,
   output logic             stat_to,
   output logic             redir_vld,
   output logic [AW-1:0]    redir_addr,
   output logic             redir_vec,
   output logic [AW-1:0]    redir_vec_addr
);
   localparam int unsigned MIN_AW = 3;

   if (N_SRC < 1) begin : g_bad_nsrc
      $error("swk_ctrl: N_SRC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("swk_ctrl: SYNC_STAGES must be at least 2");
   end
   if (AW < MIN_AW) begin : g_bad_aw
      $error("swk_ctrl: AW too small for the interrupt vector");
   end

   swk_state_e st;
   logic       is_run, is_sleep, is_wake;
   logic       pend_all, pend_wake, wake_raw;
   logic       sleep_go, clr_go, wake_go, tmo_go;
   logic       sync_q;
   logic       vec_lat;
   logic [AW-1:0] pc_lat;

   assign is_run   = (st == SW_RUN);
   assign is_sleep = (st == SW_SLEEP);
   assign is_wake  = (st == SW_WAKE);

   swk_irq_scan #(
      .N_SRC     (N_SRC),
      .WAKE_MASK (WAKE_MASK)
   ) scan_i (
      .flag     (irq_flag),
      .en       (irq_en),
      .any_pend (pend_all),
      .any_wake (pend_wake)
   );

   assign wake_raw = pend_wake | wdt_tmo;
   assign sleep_go = is_run & sleep_req & ~pend_all & ~ext_rst;
   assign clr_go   = is_run & clrwdt_req & ~ext_rst;
   assign wake_go  = is_sleep & wake_raw & ~ext_rst;
   assign tmo_go   = is_sleep & wdt_tmo & ~ext_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SW_RUN;
      end else if (ext_rst) begin
         st <= SW_RUN;
      end else begin
         unique case (st)
            SW_RUN:   if (sleep_go) st <= SW_SLEEP;
            SW_SLEEP: if (wake_raw) st <= SW_WAKE;
            SW_WAKE:  if (sync_q)   st <= SW_RUN;
            default:  st <= SW_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_lat  <= '0;
         vec_lat <= 1'b0;
      end else begin
         if (sleep_go) pc_lat  <= pc_next;
         if (wake_go)  vec_lat <= gie;
      end
   end

   swk_sync #(
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~is_wake | ext_rst),
      .d     (is_wake),
      .q     (sync_q)
   );

   swk_status status_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_take (sleep_go),
      .wdt_kick   (clr_go),
      .tmo_wake   (tmo_go),
      .pd         (stat_pd),
      .to         (stat_to)
   );

   assign wdt_clr        = sleep_go | clr_go;
   assign core_clk_en    = ~is_sleep | wake_raw | ext_rst;
   assign redir_vld      = is_wake & sync_q & ~ext_rst;
   assign redir_addr     = redir_vld ? pc_lat : '0;
   assign redir_vec      = redir_vld & vec_lat;
   assign redir_vec_addr = redir_vec ? VEC_ADDR : '0;
endmodule

// File: rtl/swk_ctrl_chk.sv
module swk_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic sleep_req,
   input logic clrwdt_req,
   input logic wdt_tmo,
   input logic ext_rst,
   input logic is_run,
   input logic is_sleep,
   input logic pend_all,
   input logic wdt_clr,
   input logic stat_pd,
   input logic stat_to,
   input logic redir_vld
);
   assert_sleep_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_run && sleep_req && !pend_all && !ext_rst) |=> (!stat_pd && stat_to));

   assert_pd_fall_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_pd) |-> $past(sleep_req));

   assert_noop_no_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_run && sleep_req && pend_all && !clrwdt_req) |-> !wdt_clr);

   assert_noop_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_run && sleep_req && pend_all && !clrwdt_req && !ext_rst)
      |=> ($stable(stat_pd) && $stable(stat_to)));

   assert_kick_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_run && clrwdt_req && !sleep_req && !ext_rst) |=> (stat_pd && stat_to));

   assert_redir_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld |=> !redir_vld);

   assert_tmo_clears_to_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sleep && wdt_tmo && !ext_rst) |=> !stat_to);

   assert_ext_no_redir_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst |=> !redir_vld);
endmodule

bind swk_ctrl swk_ctrl_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .sleep_req  (sleep_req),
   .clrwdt_req (clrwdt_req),
   .wdt_tmo    (wdt_tmo),
   .ext_rst    (ext_rst),
   .is_run     (is_run),
   .is_sleep   (is_sleep),
   .pend_all   (pend_all),
   .wdt_clr    (wdt_clr),
   .stat_pd    (stat_pd),
   .stat_to    (stat_to),
   .redir_vld  (redir_vld)
);

// File: tb/swk_ctrl_tb_top.sv
`timescale 1ns/1ps
module swk_ctrl_tb_top;
   localparam int NS = 8;
   localparam int AW = 13;
   localparam int SS = 2;
   localparam logic [NS-1:0] MASK = 8'h3F;
   localparam logic [AW-1:0] VEC  = 13'h0004;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 0, clrwdt_req = 0, wdt_tmo = 0, ext_rst = 0, gie = 0;
   logic [NS-1:0] irq_flag = '0, irq_en = '0;
   logic [AW-1:0] pc_next = '0;
   logic core_clk_en, wdt_clr, stat_pd, stat_to, redir_vld, redir_vec;
   logic [AW-1:0] redir_addr, redir_vec_addr;

   int checks = 0;
   int errors = 0;

   // reference model state: 0 running, 1 asleep, 2 waking
   int m_state = 0;
   int m_cnt = 0;
   bit m_pd = 1, m_to = 1, m_vec = 0;
   logic [AW-1:0] m_pc = '0;

   always #2 clk = ~clk;

   swk_ctrl #(.N_SRC(NS), .AW(AW), .SYNC_STAGES(SS), .WAKE_MASK(MASK), .VEC_ADDR(VEC)) dut_i (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .clrwdt_req(clrwdt_req),
      .wdt_tmo(wdt_tmo), .ext_rst(ext_rst), .gie(gie), .irq_flag(irq_flag),
      .irq_en(irq_en), .pc_next(pc_next), .core_clk_en(core_clk_en), .wdt_clr(wdt_clr),
      .stat_pd(stat_pd), .stat_to(stat_to), .redir_vld(redir_vld), .redir_addr(redir_addr),
      .redir_vec(redir_vec), .redir_vec_addr(redir_vec_addr));

   task automatic chk(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare on this cycle, then advance the model over the edge
   task automatic cyc(string tag);
      bit pa, pw, ex_clk, ex_clr, ex_rd;
      #1;
      pa = |(irq_flag & irq_en);
      pw = |(irq_flag & irq_en & MASK);
      ex_clr = !ext_rst && m_state == 0 && (clrwdt_req || (sleep_req && !pa));
      ex_clk = (m_state != 1) || pw || wdt_tmo || ext_rst;
      ex_rd  = !ext_rst && m_state == 2 && m_cnt == SS;
      chk(tag, "core_clk_en", core_clk_en, ex_clk);
      chk(tag, "wdt_clr", wdt_clr, ex_clr);
      chk(tag, "stat_pd", stat_pd, m_pd);
      chk(tag, "stat_to", stat_to, m_to);
      chk(tag, "redir_vld", redir_vld, ex_rd);
      chk(tag, "redir_addr", redir_addr, ex_rd ? m_pc : 0);
      chk(tag, "redir_vec", redir_vec, ex_rd && m_vec);
      chk(tag, "redir_vec_addr", redir_vec_addr, (ex_rd && m_vec) ? VEC : 0);
      @(posedge clk);
      if (ext_rst) begin
         m_state = 0; m_cnt = 0;
      end else if (m_state == 0) begin
         if (sleep_req && !pa) begin
            m_state = 1; m_pd = 0; m_to = 1; m_pc = pc_next;
         end else if (clrwdt_req) begin
            m_pd = 1; m_to = 1;
         end
      end else if (m_state == 1) begin
         if (pw || wdt_tmo) begin
            m_state = 2; m_cnt = 0; m_vec = gie;
            if (wdt_tmo) m_to = 0;
         end
      end else begin
         if (m_cnt == SS) m_state = 0;
         else m_cnt++;
      end
      @(negedge clk);
   endtask

   task automatic quiet();
      sleep_req = 0; clrwdt_req = 0; wdt_tmo = 0; ext_rst = 0;
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "reset stat_pd", stat_pd, 1);
      chk("R1", "reset stat_to", stat_to, 1);
      chk("R1", "reset core_clk_en", core_clk_en, 1);
      chk("R1", "reset redir_vld", redir_vld, 0);
      chk("R1", "reset wdt_clr", wdt_clr, 0);
      @(negedge clk);
      rst_n = 1;
      cyc("R1");

      // R2/R5/R6/R7: sleep, then interrupt wake with gie clear
      irq_en = 8'h04; gie = 0;
      sleep_req = 1; pc_next = 13'h0123; cyc("R2");
      quiet(); pc_next = 13'h0555;
      repeat (3) cyc("R2");
      irq_flag = 8'h04; cyc("R5");
      repeat (4) cyc("R6");
      irq_flag = '0; cyc("R7");

      // R3: sleep with pending wake-capable source
      irq_flag = 8'h04; sleep_req = 1; cyc("R3");
      sleep_req = 0; repeat (2) cyc("R3");
      irq_flag = '0;

      // R4: clear-watchdog restores both bits
      clrwdt_req = 1; cyc("R4");
      clrwdt_req = 0; cyc("R4");

      // R8/R7: watchdog wake with gie set
      gie = 1; sleep_req = 1; pc_next = 13'h0A0B; cyc("R8");
      quiet(); repeat (2) cyc("R8");
      wdt_tmo = 1; cyc("R8");
      wdt_tmo = 0; repeat (4) cyc("R7");
      gie = 0;

      // R9: non-waking patterns while asleep
      irq_en = '0; sleep_req = 1; pc_next = 13'h0042; cyc("R9");
      quiet();
      irq_flag = 8'h02; cyc("R9");
      irq_flag = '0; irq_en = 8'h02; cyc("R9");
      irq_en = 8'h80; irq_flag = 8'h80; repeat (2) cyc("R9");
      irq_en = 8'h81; irq_flag = 8'h81; cyc("R9");
      repeat (4) cyc("R9");
      irq_flag = '0; irq_en = '0; cyc("R9");

      // R9/R3: masked source still makes sleep a no-op
      irq_en = 8'h40; irq_flag = 8'h40; sleep_req = 1; cyc("R9");
      sleep_req = 0; cyc("R9");
      irq_flag = '0; irq_en = '0;

      // R10: external reset during sleep
      clrwdt_req = 1; cyc("R10");
      clrwdt_req = 0; sleep_req = 1; pc_next = 13'h0777; cyc("R10");
      sleep_req = 0; repeat (2) cyc("R10");
      ext_rst = 1; cyc("R10");
      ext_rst = 0; repeat (5) cyc("R10");

      // R11: source rises the cycle after the sleep
      irq_en = 8'h01; sleep_req = 1; pc_next = 13'h0999; cyc("R11");
      sleep_req = 0; irq_flag = 8'h01; cyc("R11");
      repeat (4) cyc("R11");
      irq_flag = '0; cyc("R11");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule